// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block decides control flow for a five-stage in-order pipeline while the branch or jump is still in decode. It evaluates the register test and computes the target address in that stage. A taken branch therefore redirects fetch one cycle after it was fetched, and it loses no more than that one slot. The block receives four inputs for the instruction in decode: the instruction word, its PC+4 and the value of the register it tests. It also receives the PC+4 of the instruction now being fetched. From these it selects the next fetch address and raises a redirect flag. It also tells the IF/ID register whether to turn its contents into a no-op.

There are two policies, and a configuration pin picks one at reset. Under predict-not-taken, fetch runs straight on and the one wrongly fetched successor is squashed. Under the single delay-slot policy, that successor is architecturally part of the program and always executes. The redirect is identical in both policies; only the squash differs. All outputs are combinational in the current decode contents. The only state is the latched policy bit.

Top module: `branch_resolve`

## Requirements
- R1: The policy is taken from `cfg_delay_slot` on clock edges while `rst_n` is low and held after that; changing `cfg_delay_slot` while out of reset has no effect on squash behaviour.
- R2: While `rst_n` is low, `redirect` and `squash` are 0 and `next_pc` equals `if_pc4`.
- R3: Opcode 6'h04 in bits 31:26 (branch-if-zero) is taken when `id_src_val` is zero; the target is `id_pc4` plus the sign-extended bits 15:0 times 4.
- R4: Opcode 6'h05 (branch-if-nonzero) is taken when `id_src_val` is not zero, with the same target rule as R3.
- R5: Opcode 6'h02 (jump) is always taken; the target is `id_pc4[31:28]`, then bits 25:0 of the instruction, then two zero bits.
- R6: A negative 16-bit offset gives a backward target (two's-complement sign extension).
- R7: When nothing is taken, `redirect` is 0 and `next_pc` equals `if_pc4`.
- R8: With `id_valid` low, or with any other opcode, nothing is taken.
- R9: Under predict-not-taken (policy 0), `squash` is 1 in exactly the cycles where `redirect` is 1.
- R10: Under delay-slot (policy 1), `squash` is never 1, while redirects still occur as in R3 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; policy is loaded during it |
| cfg_delay_slot | input | 1 | Policy select: 0 predict-not-taken, 1 one delay slot |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_instr | input | 32 | Instruction word in decode |
| id_pc4 | input | 32 | PC+4 of the decode instruction |
| id_src_val | input | 32 | Value of the tested register (bits 25:21) |
| if_pc4 | input | 32 | Sequential next address of the fetch stage |
| next_pc | output | 32 | Address to fetch next |
| redirect | output | 1 | Fetch is steered to a branch or jump target |
| squash | output | 1 | Turn IF/ID contents into a no-op |

## Verification
The bench covers the zero/non-zero boundary with the values 0, 1 and all-ones. A design that inverts or narrows the test would take the wrong direction. Backward offsets and a jump with PC+4 bits 31:28 set are included. Dropping the sign extension would send fetch far forward, and forming the jump region from the wrong bits would put the target in the wrong 256 MB region. The policy pin is toggled outside reset, and both policies are run. A design that reads the pin live, or that squashes delay slots, changes the squash count. That count is checked against the model at the end of each phase.

// File: rtl/branch_resolve.sv
module branch_resolve #(
  parameter logic [5:0] OP_BRZ  = 6'h04,
  parameter logic [5:0] OP_BRNZ = 6'h05,
  parameter logic [5:0] OP_JMP  = 6'h02
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_delay_slot,
  input  logic        id_valid,
  input  logic [31:0] id_instr,
  input  logic [31:0] id_pc4,
  input  logic [31:0] id_src_val,
  input  logic [31:0] if_pc4,
  output logic [31:0] next_pc,
  output logic        redirect,
  output logic        squash
);
  logic delay_mode;

  always_ff @(posedge clk)
    if (!rst_n) delay_mode <= cfg_delay_slot;

  wire [5:0]  opc      = id_instr[31:26];
  wire        src_zero = (id_src_val == '0);
  wire        is_jmp   = (opc == OP_JMP);
  wire        cond_hit = ((opc == OP_BRZ) && src_zero) || ((opc == OP_BRNZ) && !src_zero);
  wire        taken    = rst_n && id_valid && (is_jmp || cond_hit);

  wire [31:0] br_tgt   = id_pc4 + {{14{id_instr[15]}}, id_instr[15:0], 2'b00};
  wire [31:0] jmp_tgt  = {id_pc4[31:28], id_instr[25:0], 2'b00};

  assign redirect = taken;
  assign squash   = taken && !delay_mode;
  assign next_pc  = !taken ? if_pc4 : (is_jmp ? jmp_tgt : br_tgt);

  a_r1_policy_held: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> $stable(delay_mode));
  a_r7_fallthrough: assert property (@(posedge clk) disable iff (!rst_n) !redirect |-> next_pc == if_pc4);
  a_r5_jump_taken:  assert property (@(posedge clk) disable iff (!rst_n) (id_valid && opc == OP_JMP) |-> redirect);
  a_r8_idle_quiet:  assert property (@(posedge clk) disable iff (!rst_n) !id_valid |-> !redirect);
  a_r9_squash_ptk:  assert property (@(posedge clk) disable iff (!rst_n) squash |-> redirect);
  a_r10_no_squash:  assert property (@(posedge clk) disable iff (!rst_n) delay_mode |-> !squash);
endmodule

// File: tb/branch_resolve_test.sv
module branch_resolve_test;
  logic clk = 0, rst_n = 0, cfg = 0, vld = 0;
  logic [31:0] instr = 0, pc4 = 0, src = 0, fpc4 = 0;
  logic [31:0] npc;
  logic rdr, sq;
  int total = 0, bad = 0, cyc = 0;
  int sq_seen = 0, sq_exp = 0;
  bit model_delay = 0;

  always #10 clk = ~clk;

  branch_resolve uut (.clk(clk), .rst_n(rst_n), .cfg_delay_slot(cfg), .id_valid(vld),
    .id_instr(instr), .id_pc4(pc4), .id_src_val(src), .if_pc4(fpc4),
    .next_pc(npc), .redirect(rdr), .squash(sq));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      total++; bad++;
      $display("FAIL watchdog: actual cyc=%0d expected <5000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural model of one decode cycle
  task automatic step(input string req, input bit v, input int op, input logic [25:0] low,
                      input logic [31:0] p4, input logic [31:0] s, input logic [31:0] f4);
    bit tk;
    longint tgt;
    @(negedge clk);
    vld = v; instr = {op[5:0], low}; pc4 = p4; src = s; fpc4 = f4;
    #3;
    tk = 0; tgt = f4;
    if (rst_n && v) begin
      if (op == 2) begin tk = 1; tgt = (p4 & 32'hF000_0000) | (longint'(low) * 4); end
      else if ((op == 4 && s == 0) || (op == 5 && s != 0)) begin
        tk = 1; tgt = (longint'(p4) + longint'($signed(low[15:0])) * 4) & 64'hFFFF_FFFF;
      end
    end
    chk({req, " redirect"}, {31'b0, rdr}, {31'b0, tk});
    chk({req, " next_pc"}, npc, tgt[31:0]);
    chk({req, " squash"}, {31'b0, sq}, {31'b0, tk && !model_delay});
    if (sq) sq_seen++;
    if (tk && !model_delay) sq_exp++;
  endtask

  task automatic program_set();
    step("R3 brz taken", 1, 4, 26'h0000010, 32'h100, 0, 32'h104);
    step("R3 brz not taken", 1, 4, 26'h0000010, 32'h104, 1, 32'h108);
    step("R4 brnz taken", 1, 5, 26'h0000003, 32'h200, 32'hFFFF_FFFF, 32'h204);
    step("R4 brnz not taken", 1, 5, 26'h0000003, 32'h204, 0, 32'h208);
    step("R6 backward", 1, 5, 26'h000FFFC, 32'h400, 1, 32'h404);
    step("R6 back min", 1, 4, 26'h0008000, 32'h0004_0000, 0, 32'h0004_0004);
    step("R5 jump", 1, 2, 26'h3AB_CDEF, 32'hA000_0010, 0, 32'hA000_0014);
    step("R5 jump zero src", 1, 2, 26'h0000001, 32'h0000_0008, 5, 32'h0000_000C);
    step("R8 invalid", 0, 2, 26'h0000040, 32'h500, 0, 32'h504);
    step("R8 other op", 1, 6'h23, 26'h0000040, 32'h504, 0, 32'h508);
    step("R7 idle", 1, 0, 26'h0, 32'h508, 0, 32'h50C);
  endtask

  initial begin
    cfg = 0; rst_n = 0;
    step("R2 reset", 1, 2, 26'h0000100, 32'h40, 0, 32'h44);
    step("R2 reset brz", 1, 4, 26'h0000100, 32'h40, 0, 32'h44);
    @(negedge clk); rst_n = 1;
    model_delay = 0; sq_seen = 0; sq_exp = 0;
    program_set();
    cfg = 1;  // R1: pin change outside reset ignored
    program_set();
    chk("R9 squash count", sq_seen, sq_exp);
    chk("R1 squash count nonzero", {31'b0, sq_seen > 0}, 32'd1);

    @(negedge clk); rst_n = 0; cfg = 1;
    @(negedge clk); rst_n = 1;
    model_delay = 1; sq_seen = 0; sq_exp = 0;
    cfg = 0;  // R1: ignored again
    program_set();
    chk("R10 no squash in delay mode", sq_seen, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule